// File: doc/BRIEF.md
# PCIe TLP Bandwidth Filter Counter

This block watches a stream of transaction-layer packet descriptors, one per cycle, and builds a bandwidth figure from the packets that pass a set of filters. Each descriptor gives the root-port index, the requester ID, the header length and the payload length in dwords, and an event class. The class is either bandwidth (add dwords) or count (add one per packet).

Configuration is held by an outside register block and is presented as static inputs. It selects a target filter, a trigger, a threshold gate, and which parts of each packet are summed. The target filter is either a port bitmap or a requester-ID match, never both.

The trigger keeps bandwidth counting closed until a first packet crosses a length bound. The threshold gate qualifies each bandwidth packet by its length. The accumulator saturates rather than wrapping, and a synchronous clear resets it. The same clear is pulsed whenever software rewrites the configuration.

Top module: `tlp_bw_counter`

## Requirements
- R1: With the port filter enabled, a packet is counted only when bit `tlp_port_i` of `cfg_port_map_i` is set, where bit n stands for root port n; with it disabled, every port passes.
- R2: With the requester filter enabled, a bandwidth packet is counted only when `tlp_rid_i` equals `cfg_rid_i`; count-class packets are not affected by this filter.
- R3: Enabling the port filter and the requester filter together is a configuration error: nothing is added and no trigger arms while it lasts.
- R4: With `cfg_one_port_i` set and the port filter enabled, a bitmap with a number of set bits other than one is a configuration error with the same effect as R3.
- R5: With the trigger enabled, bandwidth packets are not added until the first target-passing bandwidth packet whose payload is greater than 2^`cfg_trig_exp_i` dwords (`cfg_trig_lt_i`=0) or less than it (`cfg_trig_lt_i`=1); that packet is itself eligible for counting and `armed_o` rises in the cycle after it.
- R6: Once `armed_o` is high it stays high until `clr_i`.
- R7: With the threshold gate enabled, a bandwidth packet is added only if its payload is greater than 2^`cfg_thr_exp_i` dwords (`cfg_thr_lt_i`=0) or less than it (`cfg_thr_lt_i`=1); equal lengths fail in both modes.
- R8: For bandwidth packets the amount added follows `cfg_len_sel_i`: 2'b01 adds payload dwords, 2'b10 adds header dwords, 2'b11 adds both; when `cfg_len_set_i` is 0 the selector is taken as 2'b11.
- R9: An effective selector of 2'b00 adds nothing and sets `cfg_err_o`, which stays set until `clr_i`; every configuration error of R3 and R4 also sets it.
- R10: A count-class packet (`tlp_bw_i`=0) that passes the port filter adds exactly one, independent of the trigger, the threshold and the selector.
- R11: The accumulator saturates at its all-ones value and never wraps.
- R12: `clr_i` zeroes the accumulator, `armed_o` and `cfg_err_o` in the next cycle, and a packet presented in the same cycle is dropped.
- R13: After reset the accumulator, `armed_o` and `cfg_err_o` are zero; every update is visible one cycle after the packet is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tlp_valid_i | input | 1 | Descriptor valid this cycle |
| tlp_port_i | input | PORT_W (4) | Root-port index of the packet |
| tlp_rid_i | input | 16 | Requester ID (bus/device/function) |
| tlp_hdr_dw_i | input | HDR_W (3) | Header length in dwords |
| tlp_pld_dw_i | input | LEN_W (11) | Payload length in dwords |
| tlp_bw_i | input | 1 | 1: bandwidth class, 0: count class |
| cfg_port_en_i | input | 1 | Port bitmap filter enable |
| cfg_port_map_i | input | NPORT (16) | Selected root ports |
| cfg_one_port_i | input | 1 | Event allows only a single port |
| cfg_rid_en_i | input | 1 | Requester-ID filter enable |
| cfg_rid_i | input | 16 | Requester ID to match |
| cfg_trig_en_i | input | 1 | Trigger enable |
| cfg_trig_exp_i | input | EXP_W (4) | Trigger bound exponent |
| cfg_trig_lt_i | input | 1 | Trigger fires on shorter (1) or longer (0) |
| cfg_thr_en_i | input | 1 | Threshold gate enable |
| cfg_thr_exp_i | input | EXP_W (4) | Threshold bound exponent |
| cfg_thr_lt_i | input | 1 | Threshold passes shorter (1) or longer (0) |
| cfg_len_set_i | input | 1 | Selector written; 0 means use both |
| cfg_len_sel_i | input | 2 | Length composition selector |
| clr_i | input | 1 | Synchronous clear of counter and state |
| acc_o | output | ACC_W (64) | Saturating accumulator |
| armed_o | output | 1 | Trigger has fired |
| cfg_err_o | output | 1 | Sticky configuration error |

## Verification
On every cycle the assertions check that the accumulator only grows between clears, that a clear empties it, that a bad configuration freezes it, and that the trigger and error flags never drop without a clear. Which packets are actually counted, and by how much, cannot be judged cycle by cycle from the outputs. The bench's scenarios show this: the port bits 0 and 8, requester matching per class, both trigger polarities with the firing packet counted, threshold edges at exactly the bound, each selector value, saturation, and a clear coinciding with a packet.

// File: rtl/tlp_bw_pkg.sv
`timescale 1ns/1ps
package tlp_bw_pkg;
  typedef enum logic [1:0] {
    LSEL_RSVD = 2'b00,
    LSEL_PLD  = 2'b01,
    LSEL_HDR  = 2'b10,
    LSEL_BOTH = 2'b11
  } len_sel_e;
endpackage

// File: rtl/tlp_target_flt.sv
`timescale 1ns/1ps
module tlp_target_flt #(
  parameter int NPORT  = 16,
  parameter int PORT_W = $clog2(NPORT),
  parameter int RID_W  = 16
) (
  input  logic              port_en_i,
  input  logic [NPORT-1:0]  port_map_i,
  input  logic              one_port_i,
  input  logic              rid_en_i,
  input  logic [RID_W-1:0]  rid_i,
  input  logic [PORT_W-1:0] tlp_port_i,
  input  logic [RID_W-1:0]  tlp_rid_i,
  input  logic              tlp_bw_i,
  output logic              hit_o,
  output logic              bad_o
);
  logic port_ok, rid_ok, multi_bad;

  assign port_ok   = !port_en_i || port_map_i[tlp_port_i];
  // requester match applies to bandwidth events only
  assign rid_ok    = !rid_en_i || !tlp_bw_i || (tlp_rid_i == rid_i);
  assign multi_bad = one_port_i && port_en_i && ($countones(port_map_i) != 1);
  assign hit_o     = port_ok && rid_ok;
  assign bad_o     = (port_en_i && rid_en_i) || multi_bad;
endmodule

// File: rtl/tlp_len_gate.sv
`timescale 1ns/1ps
module tlp_len_gate #(
  parameter int LEN_W = 11,
  parameter int EXP_W = 4
) (
  input  logic             en_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic             lt_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             hit_o,
  output logic             pass_o
);
  localparam int LIM_W = (1 << EXP_W) + 1;
  localparam int CMP_W = (LIM_W > LEN_W) ? LIM_W : LEN_W;

  logic [CMP_W-1:0] lim, len_x;

  assign lim    = CMP_W'(1) << exp_i;
  assign len_x  = CMP_W'(len_i);
  assign hit_o  = lt_i ? (len_x < lim) : (len_x > lim);
  assign pass_o = !en_i || hit_o;
endmodule

// File: rtl/tlp_sat_acc.sv
`timescale 1ns/1ps
module tlp_sat_acc #(
  parameter int ACC_W = 64,
  parameter int AMT_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             add_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W:0]   sum;
  logic [ACC_W-1:0] acc_q;

  assign sum = {1'b0, acc_q} + (ACC_W+1)'(amt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (add_i)  acc_q <= sum[ACC_W] ? '1 : sum[ACC_W-1:0];
  end

  assign acc_o = acc_q;

  AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> acc_q >= $past(acc_q)); // R11
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> acc_q == '0); // R12
endmodule

// File: rtl/tlp_bw_counter.sv
`timescale 1ns/1ps
module tlp_bw_counter
  import tlp_bw_pkg::*;
#(
  parameter int NPORT  = 16,
  parameter int PORT_W = $clog2(NPORT),
  parameter int RID_W  = 16,
  parameter int HDR_W  = 3,
  parameter int LEN_W  = 11,
  parameter int EXP_W  = 4,
  parameter int ACC_W  = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tlp_valid_i,
  input  logic [PORT_W-1:0] tlp_port_i,
  input  logic [RID_W-1:0]  tlp_rid_i,
  input  logic [HDR_W-1:0]  tlp_hdr_dw_i,
  input  logic [LEN_W-1:0]  tlp_pld_dw_i,
  input  logic              tlp_bw_i,
  input  logic              cfg_port_en_i,
  input  logic [NPORT-1:0]  cfg_port_map_i,
  input  logic              cfg_one_port_i,
  input  logic              cfg_rid_en_i,
  input  logic [RID_W-1:0]  cfg_rid_i,
  input  logic              cfg_trig_en_i,
  input  logic [EXP_W-1:0]  cfg_trig_exp_i,
  input  logic              cfg_trig_lt_i,
  input  logic              cfg_thr_en_i,
  input  logic [EXP_W-1:0]  cfg_thr_exp_i,
  input  logic              cfg_thr_lt_i,
  input  logic              cfg_len_set_i,
  input  logic [1:0]        cfg_len_sel_i,
  input  logic              clr_i,
  output logic [ACC_W-1:0]  acc_o,
  output logic              armed_o,
  output logic              cfg_err_o
);
  localparam int AMT_W = ((LEN_W > HDR_W) ? LEN_W : HDR_W) + 1;
  localparam int NGATE = 2; // 0: trigger, 1: threshold

  len_sel_e         sel;
  logic             tgt_hit, tgt_bad, cfg_bad, live, fire, open_q, add;
  logic [AMT_W-1:0] amt;
  logic             armed_q, err_q;
  logic [NGATE-1:0] g_en, g_lt, g_hit, g_pass;
  logic [EXP_W-1:0] g_exp [NGATE];

  assign sel = cfg_len_set_i ? len_sel_e'(cfg_len_sel_i) : LSEL_BOTH;

  tlp_target_flt #(.NPORT(NPORT), .PORT_W(PORT_W), .RID_W(RID_W)) u_tgt (
    .port_en_i (cfg_port_en_i),
    .port_map_i(cfg_port_map_i),
    .one_port_i(cfg_one_port_i),
    .rid_en_i  (cfg_rid_en_i),
    .rid_i     (cfg_rid_i),
    .tlp_port_i(tlp_port_i),
    .tlp_rid_i (tlp_rid_i),
    .tlp_bw_i  (tlp_bw_i),
    .hit_o     (tgt_hit),
    .bad_o     (tgt_bad)
  );

  assign g_en     = {cfg_thr_en_i,  cfg_trig_en_i};
  assign g_lt     = {cfg_thr_lt_i,  cfg_trig_lt_i};
  assign g_exp[0] = cfg_trig_exp_i;
  assign g_exp[1] = cfg_thr_exp_i;

  for (genvar gi = 0; gi < NGATE; gi++) begin : g_gate
    tlp_len_gate #(.LEN_W(LEN_W), .EXP_W(EXP_W)) u_gate (
      .en_i  (g_en[gi]),
      .exp_i (g_exp[gi]),
      .lt_i  (g_lt[gi]),
      .len_i (tlp_pld_dw_i),
      .hit_o (g_hit[gi]),
      .pass_o(g_pass[gi])
    );
  end

  assign cfg_bad = tgt_bad || (sel == LSEL_RSVD);
  assign live    = tlp_valid_i && !cfg_bad && tgt_hit;
  assign fire    = live && tlp_bw_i && cfg_trig_en_i && g_hit[0];
  // firing packet counts in its own cycle
  assign open_q  = !cfg_trig_en_i || armed_q || fire;
  assign add     = live && (!tlp_bw_i || (open_q && g_pass[1]));

  always_comb begin
    amt = '0;
    if (!tlp_bw_i) amt = AMT_W'(1);
    else begin
      if (sel[0]) amt = amt + AMT_W'(tlp_pld_dw_i);
      if (sel[1]) amt = amt + AMT_W'(tlp_hdr_dw_i);
    end
  end

  tlp_sat_acc #(.ACC_W(ACC_W), .AMT_W(AMT_W)) u_acc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clr_i),
    .add_i (add),
    .amt_i (amt),
    .acc_o (acc_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      err_q   <= 1'b0;
    end else if (clr_i) begin
      armed_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (fire)    armed_q <= 1'b1;
      if (cfg_bad) err_q   <= 1'b1;
    end
  end

  assign armed_o   = armed_q;
  assign cfg_err_o = err_q;

  AST_ARMED_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && !clr_i |=> armed_q); // R6
  AST_ERR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q && !clr_i |=> err_q); // R9
  AST_BAD_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_bad && !clr_i |=> $stable(acc_o) && cfg_err_o); // R3
  AST_NO_ARM_BAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_bad && !armed_q && !clr_i |=> !armed_q); // R4
endmodule

// File: tb/sim_tlp_bw_counter.sv
`timescale 1ns/1ps
module sim_tlp_bw_counter;
  localparam int ACC_W = 20;
  localparam logic [ACC_W-1:0] ACC_MAX = '1;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic        v, bw, pen, one, ren, ten, tlt, hen, hlt, lset, clr;
  logic [3:0]  port, texp, hexp;
  logic [15:0] rid, map, crid;
  logic [2:0]  hdr;
  logic [10:0] pld;
  logic [1:0]  lsel;
  logic [ACC_W-1:0] acc;
  logic armed, err;

  logic [ACC_W-1:0] m_acc;
  logic m_armed, m_err;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  tlp_bw_counter #(.ACC_W(ACC_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tlp_valid_i(v), .tlp_port_i(port),
    .tlp_rid_i(rid), .tlp_hdr_dw_i(hdr), .tlp_pld_dw_i(pld), .tlp_bw_i(bw),
    .cfg_port_en_i(pen), .cfg_port_map_i(map), .cfg_one_port_i(one),
    .cfg_rid_en_i(ren), .cfg_rid_i(crid), .cfg_trig_en_i(ten),
    .cfg_trig_exp_i(texp), .cfg_trig_lt_i(tlt), .cfg_thr_en_i(hen),
    .cfg_thr_exp_i(hexp), .cfg_thr_lt_i(hlt), .cfg_len_set_i(lset),
    .cfg_len_sel_i(lsel), .clr_i(clr), .acc_o(acc), .armed_o(armed),
    .cfg_err_o(err));

  function automatic bit cmp_len(input logic [10:0] l, input logic [3:0] e, input logic lt);
    int lim = 1 << e;
    return lt ? (int'(l) < lim) : (int'(l) > lim);
  endfunction

  function automatic logic [ACC_W-1:0] sat_add(input logic [ACC_W-1:0] a, input int amt);
    longint s = longint'(a) + longint'(amt);
    return (s > longint'(ACC_MAX)) ? ACC_MAX : ACC_W'(s);
  endfunction

  task automatic model();
    logic [1:0] es = lset ? lsel : 2'b11;
    bit bad = (pen && ren) || (es == 2'b00) || (one && pen && $countones(map) != 1);
    bit tgt, fire, go, thr;
    int amt;
    if (clr) begin m_acc = '0; m_armed = 0; m_err = 0; return; end
    if (bad) m_err = 1;
    if (!v || bad) return;
    tgt = !pen || map[port];
    if (bw) begin
      tgt  = tgt && (!ren || rid == crid);
      fire = ten && tgt && cmp_len(pld, texp, tlt);
      go   = !ten || m_armed || fire;
      thr  = !hen || cmp_len(pld, hexp, hlt);
      amt  = (es[0] ? int'(pld) : 0) + (es[1] ? int'(hdr) : 0);
      if (tgt && go && thr) m_acc = sat_add(m_acc, amt);
      if (fire) m_armed = 1;
    end else if (tgt) m_acc = sat_add(m_acc, 1);
  endtask

  task automatic chk(input string tag, input longint got, input longint exp_v, input string what);
    n_chk++;
    if (got != exp_v) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, got, exp_v);
    end
  endtask

  task automatic cyc(input string tag);
    @(posedge clk);
    model();
    @(negedge clk);
    chk(tag, acc, m_acc, "acc");
    chk(tag, armed, m_armed, "armed");
    chk(tag, err, m_err, "err");
  endtask

  task automatic defaults();
    v = 0; bw = 1; port = 0; rid = 0; hdr = 0; pld = 0;
    pen = 0; map = 0; one = 0; ren = 0; crid = 0; ten = 0; texp = 0; tlt = 0;
    hen = 0; hexp = 0; hlt = 0; lset = 1; lsel = 2'b11; clr = 0;
  endtask

  task automatic do_clr(input string tag);
    clr = 1; cyc(tag); clr = 0;
  endtask

  task automatic pkt(input string tag, input logic [3:0] p, input logic [15:0] r,
                     input logic [2:0] h, input logic [10:0] l, input logic b);
    v = 1; port = p; rid = r; hdr = h; pld = l; bw = b;
    cyc(tag);
    v = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    defaults();
    m_acc = '0; m_armed = 0; m_err = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R13", acc, 0, "acc"); chk("R13", armed, 0, "armed"); chk("R13", err, 0, "err");

    // R1: bits 0 and 8 select different ports
    pen = 1; map = 16'h0001; do_clr("R1");
    pkt("R1", 0, 0, 3, 5, 1); chk("R1", acc, 8, "acc port0");
    pkt("R1", 8, 0, 3, 5, 1); chk("R1", acc, 8, "acc port8 blocked");
    map = 16'h0100; do_clr("R1");
    pkt("R1", 8, 0, 1, 6, 1); pkt("R1", 0, 0, 1, 6, 1); chk("R1", acc, 7, "acc port8 only");
    pen = 0; pkt("R1", 3, 0, 1, 1, 1); chk("R1", acc, 9, "acc filter off");

    // R2 / R10: requester filter applies to bandwidth only
    ren = 1; crid = 16'h3900; do_clr("R2");
    pkt("R2", 1, 16'h3900, 2, 4, 1); pkt("R2", 1, 16'h3901, 2, 4, 1);
    chk("R2", acc, 6, "acc rid match");
    pkt("R10", 1, 16'h1234, 2, 40, 0); chk("R10", acc, 7, "acc count class");

    // R3: both target filters
    pen = 1; map = 16'h0001; do_clr("R3");
    pkt("R3", 0, 16'h3900, 2, 4, 1); chk("R3", acc, 0, "acc"); chk("R3", err, 1, "err");
    ren = 0;

    // R4: single-port event
    one = 1; map = 16'h0101; do_clr("R4");
    pkt("R4", 0, 0, 2, 4, 1); chk("R4", acc, 0, "acc"); chk("R4", err, 1, "err");
    map = 16'h0100; do_clr("R4");
    pkt("R4", 8, 0, 2, 4, 1); chk("R4", acc, 6, "acc"); chk("R4", err, 0, "err");
    one = 0; pen = 0;

    // R5/R6: trigger longer than 16
    ten = 1; texp = 4; tlt = 0; do_clr("R5");
    pkt("R5", 0, 0, 1, 10, 1); pkt("R5", 0, 0, 1, 16, 1); chk("R5", acc, 0, "acc pre");
    pkt("R10", 0, 0, 1, 1, 0); chk("R10", acc, 1, "count class bypasses trigger");
    pkt("R5", 0, 0, 1, 20, 1); chk("R5", acc, 22, "firing pkt counted"); chk("R5", armed, 1, "armed");
    pkt("R6", 0, 0, 1, 3, 1); chk("R6", acc, 26, "acc after"); chk("R6", armed, 1, "armed held");
    do_clr("R12"); chk("R12", armed, 0, "armed cleared");
    // trigger shorter than 16
    tlt = 1;
    pkt("R5", 0, 0, 1, 20, 1); pkt("R5", 0, 0, 1, 8, 1); chk("R5", acc, 9, "lt fire");
    ten = 0;

    // R7: threshold less than 8
    hen = 1; hexp = 3; hlt = 1; do_clr("R7");
    pkt("R7", 0, 0, 1, 4, 1); pkt("R7", 0, 0, 1, 9, 1); pkt("R7", 0, 0, 1, 8, 1);
    chk("R7", acc, 5, "acc lt");
    hlt = 0; do_clr("R7");
    pkt("R7", 0, 0, 1, 8, 1); pkt("R7", 0, 0, 1, 9, 1); chk("R7", acc, 10, "acc gt");
    hen = 0;

    // R8: selector
    lsel = 2'b01; do_clr("R8"); pkt("R8", 0, 0, 4, 7, 1); chk("R8", acc, 7, "payload");
    lsel = 2'b10; do_clr("R8"); pkt("R8", 0, 0, 4, 7, 1); chk("R8", acc, 4, "header");
    lsel = 2'b11; do_clr("R8"); pkt("R8", 0, 0, 4, 7, 1); chk("R8", acc, 11, "both");
    lset = 0; lsel = 2'b00; do_clr("R8"); pkt("R8", 0, 0, 4, 7, 1); chk("R8", acc, 11, "default");

    // R9: reserved selector
    lset = 1; lsel = 2'b00; do_clr("R9");
    pkt("R9", 0, 0, 4, 7, 1); chk("R9", acc, 0, "acc"); chk("R9", err, 1, "err");
    lsel = 2'b11; cyc("R9"); chk("R9", err, 1, "sticky");
    do_clr("R9"); chk("R9", err, 0, "cleared");

    // R12: clear with a packet in the same cycle
    pkt("R12", 0, 0, 2, 2, 1);
    v = 1; pld = 30; clr = 1; cyc("R12"); clr = 0; v = 0;
    chk("R12", acc, 0, "pkt dropped");

    // R11: saturation
    for (int i = 0; i < 1100; i++) pkt("R11", 0, 0, 4, 1023, 1);
    chk("R11", acc, ACC_MAX, "saturated");

    // random segments
    for (int s = 0; s < 60; s++) begin
      pen  = ($urandom % 3) == 0;  map  = 16'($urandom);
      one  = ($urandom % 4) == 0;  ren  = ($urandom % 4) == 0;
      crid = 16'($urandom % 4);    ten  = $urandom % 2;
      texp = 4'($urandom % 8);     tlt  = $urandom % 2;
      hen  = $urandom % 2;         hexp = 4'($urandom % 8);
      hlt  = $urandom % 2;         lset = ($urandom % 5) != 0;
      lsel = 2'($urandom);
      do_clr("R12");
      for (int k = 0; k < 50; k++) begin
        v = $urandom % 2; port = 4'($urandom); rid = 16'($urandom % 4);
        hdr = 3'($urandom % 5); pld = 11'($urandom % 300); bw = ($urandom % 4) != 0;
        cyc("R8");
      end
      v = 0;
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule